// File: doc/BRIEF.md
# Dual-Mode Transition Controller

This block decides which of two users owns a shared serial data line. After power-up a free-running streamer owns it and sends memory contents on each stream-clock pulse. As soon as the addressed-bus clock shows a falling edge, the streamer is silenced. The block then waits in a pending state in which the bus slave may only compare incoming addresses. If the slave reports that its own control byte was acknowledged, the block hands the line to the bus slave for good. If instead 128 stream-clock pulses arrive with no further bus-clock falling edge, the block gives the line back to the streamer and tells it to restart from the first byte, most significant bit first.

All inputs are single-cycle pulses that are already synchronised to `clk`. Edge detection, protocol decoding and the memory array sit outside this block. The three enables are decoded from one state register, so exactly one of them is high at any time. Bus ownership can only be left through reset.

Top module: `mode_arbiter`

## Requirements
- R1: After reset, `streamEn` is 1 and `matchEn`, `slaveEn` and `streamRestart` are 0.
- R2: A `busClkFall` pulse while streaming makes `matchEn` 1 and `streamEn` 0 from the next cycle on.
- R3: While streaming, `streamClkRise` pulses do not change the enables.
- R4: In the pending state, the 128th `streamClkRise` pulse counted since entry or since the last clear returns the block to streaming in the next cycle. `streamRestart` is 1 for exactly that one cycle.
- R5: Every `busClkFall` pulse in the pending state clears the pulse count, so that 127 further pulses leave the block pending.
- R6: A `ctrlMatch` pulse in the pending state makes `slaveEn` 1 from the next cycle on.
- R7: Once `slaveEn` is 1, no combination of `busClkFall`, `streamClkRise` or `ctrlMatch` changes the enables until reset.
- R8: In the pending state, `ctrlMatch` wins over a pulse that would complete the count. A `busClkFall` in the same cycle as a `streamClkRise` clears the count and the pulse is not counted.
- R9: Exactly one of `streamEn`, `matchEn` and `slaveEn` is 1 in every cycle.
- R10: A `ctrlMatch` pulse while streaming is ignored: the enables stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset (power-up) |
| busClkFall | input | 1 | One-cycle pulse for a falling edge of the bus clock |
| streamClkRise | input | 1 | One-cycle pulse for a rising edge of the stream clock |
| ctrlMatch | input | 1 | One-cycle pulse: the bus slave acknowledged its own control byte |
| streamEn | output | 1 | The streamer owns the data line |
| matchEn | output | 1 | The bus slave may only match addresses (pending state) |
| slaveEn | output | 1 | The bus slave fully owns the data line |
| streamRestart | output | 1 | One-cycle pulse: the streamer restarts at address 0, MSB first |

## Verification
The hardest situations to reach are the count boundaries in the pending state. These are the 127th versus the 128th pulse, a clear arriving on the very pulse that would have been counted, and a control-byte match coinciding with the 128th pulse. Each of them needs long, exactly counted pulse trains with the colliding event placed in one specific cycle. The stimulus builds these trains in loops, some with idle gaps between pulses. It places the colliding pulse by count, and a behavioural model that keeps its own integer count checks every cycle.

// File: rtl/mode_arbiter_pkg.sv
package mode_arbiter_pkg;

  typedef enum logic [1:0] {
    MODE_STREAM  = 2'd0,
    MODE_PENDING = 2'd1,
    MODE_BUS     = 2'd2
  } mode_e;

  // Strobes from the control FSM to the pulse-count datapath.
  typedef struct packed {
    logic cntClear;
    logic cntIncr;
    logic restart;
  } arb_strobe_t;

endpackage

// File: rtl/mode_arbiter_ctrl.sv
module mode_arbiter_ctrl
  import mode_arbiter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busClkFall,
  input  logic        streamClkRise,
  input  logic        ctrlMatch,
  input  logic        lastPulse,
  output arb_strobe_t strobe,
  output logic        streamEn,
  output logic        matchEn,
  output logic        slaveEn
);

  mode_e modeQ, modeD;

  always_comb begin
    modeD           = modeQ;
    strobe          = '0;
    unique case (modeQ)
      MODE_STREAM: begin
        if (busClkFall) begin
          modeD           = MODE_PENDING;
          strobe.cntClear = 1'b1;
        end
      end
      MODE_PENDING: begin
        if (ctrlMatch) begin
          modeD = MODE_BUS;
        end else if (busClkFall) begin
          strobe.cntClear = 1'b1;
        end else if (streamClkRise) begin
          if (lastPulse) begin
            modeD           = MODE_STREAM;
            strobe.cntClear = 1'b1;
            strobe.restart  = 1'b1;
          end else begin
            strobe.cntIncr = 1'b1;
          end
        end
      end
      MODE_BUS: begin
        modeD = MODE_BUS;
      end
      default: begin
        modeD = MODE_STREAM;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_STREAM;
    else       modeQ <= modeD;
  end

  assign streamEn = (modeQ == MODE_STREAM);
  assign matchEn  = (modeQ == MODE_PENDING);
  assign slaveEn  = (modeQ == MODE_BUS);

  AST_ENABLES_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones({streamEn, matchEn, slaveEn}) == 1);  // R9
  AST_ENTER_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    streamEn && busClkFall |=> matchEn);  // R2
  AST_MATCH_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    matchEn && ctrlMatch |=> slaveEn);  // R6
  AST_BUS_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    slaveEn |=> slaveEn);  // R7
  AST_STREAM_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    streamEn && !busClkFall |=> streamEn);  // R10

endmodule

// File: rtl/mode_arbiter_dp.sv
module mode_arbiter_dp
  import mode_arbiter_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PULSE_LIMIT = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  arb_strobe_t strobe,
  output logic        lastPulse,
  output logic        streamRestart
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LIMIT - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pulseCnt;
  logic             restartQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.cntClear) begin
      pulseCnt <= '0;
    end else if (strobe.cntIncr && (pulseCnt != CNT_MAX)) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) restartQ <= 1'b0;
    else       restartQ <= strobe.restart;
  end

  assign lastPulse     = (pulseCnt == CNT_LAST);
  assign streamRestart = restartQ;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CNT_LAST);  // R4
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    streamRestart |=> !streamRestart);  // R4
  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> pulseCnt == '0);  // R5

endmodule

// File: rtl/mode_arbiter.sv
module mode_arbiter
  import mode_arbiter_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PULSE_LIMIT = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic busClkFall,
  input  logic streamClkRise,
  input  logic ctrlMatch,
  output logic streamEn,
  output logic matchEn,
  output logic slaveEn,
  output logic streamRestart
);

  arb_strobe_t strobe;
  logic        lastPulse;

  mode_arbiter_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .busClkFall   (busClkFall),
    .streamClkRise(streamClkRise),
    .ctrlMatch    (ctrlMatch),
    .lastPulse    (lastPulse),
    .strobe       (strobe),
    .streamEn     (streamEn),
    .matchEn      (matchEn),
    .slaveEn      (slaveEn)
  );

  mode_arbiter_dp #(
    .CNT_W      (CNT_W),
    .PULSE_LIMIT(PULSE_LIMIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .lastPulse    (lastPulse),
    .streamRestart(streamRestart)
  );

  AST_RESTART_ONLY_STREAM: assert property (@(posedge clk) disable iff (!rstN)
    streamRestart |-> streamEn && $past(matchEn));  // R4

endmodule

// File: tb/sim_mode_arbiter.sv
module sim_mode_arbiter;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClkFall = 1'b0;
  logic streamClkRise = 1'b0;
  logic ctrlMatch = 1'b0;
  logic streamEn, matchEn, slaveEn, streamRestart;

  int checks = 0;
  int fails = 0;
  string phase = "R1";
  bit compareOn = 1'b0;

  // Reference model: 0 stream, 1 pending, 2 bus
  int mMode = 0;
  int mCnt = 0;
  bit mRestart = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_arbiter u0 (
    .clk(clk), .rstN(rstN), .busClkFall(busClkFall),
    .streamClkRise(streamClkRise), .ctrlMatch(ctrlMatch),
    .streamEn(streamEn), .matchEn(matchEn), .slaveEn(slaveEn),
    .streamRestart(streamRestart)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mCnt = 0; mRestart = 1'b0;
    end else begin
      mRestart = 1'b0;
      if (mMode == 0) begin
        if (busClkFall) begin mMode = 1; mCnt = 0; end
      end else if (mMode == 1) begin
        if (ctrlMatch) mMode = 2;
        else if (busClkFall) mCnt = 0;
        else if (streamClkRise) begin
          mCnt = mCnt + 1;
          if (mCnt == 128) begin mMode = 0; mCnt = 0; mRestart = 1'b1; end
        end
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R9 also: one-hot enables).
  always @(negedge clk) begin
    if (compareOn) begin
      check(streamEn, mMode == 0, phase, "streamEn vs model");
      check(matchEn, mMode == 1, phase, "matchEn vs model");
      check(slaveEn, mMode == 2, phase, "slaveEn vs model");
      check(streamRestart, mRestart, phase, "streamRestart vs model");
      check(($countones({streamEn, matchEn, slaveEn}) == 1), 1'b1, "R9", "one-hot enables");
    end
  end

  task automatic step(input logic bf, input logic sr, input logic m);
    busClkFall = bf; streamClkRise = sr; ctrlMatch = m;
    @(negedge clk);
    busClkFall = 1'b0; streamClkRise = 1'b0; ctrlMatch = 1'b0;
  endtask

  task automatic pulses(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b1, 1'b0);
      if (gaps && (i % 3 == 0)) step(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic doReset();
    compareOn = 1'b0;
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareOn = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareOn = 1'b1;

    phase = "R1";
    check(streamEn, 1'b1, "R1", "streamEn after reset");
    check(matchEn, 1'b0, "R1", "matchEn after reset");
    check(slaveEn, 1'b0, "R1", "slaveEn after reset");
    check(streamRestart, 1'b0, "R1", "streamRestart after reset");

    phase = "R3";
    pulses(20, 1'b1);
    check(streamEn, 1'b1, "R3", "stream pulses keep streaming");
    phase = "R10";
    for (int i = 0; i < 4; i++) step(1'b0, i[0], 1'b1);
    check(streamEn, 1'b1, "R10", "match while streaming ignored");
    check(slaveEn, 1'b0, "R10", "no bus mode from streaming");

    phase = "R2";
    step(1'b1, 1'b0, 1'b0);
    check(matchEn, 1'b1, "R2", "pending after bus fall");
    check(streamEn, 1'b0, "R2", "streaming stopped");

    phase = "R5";
    pulses(127, 1'b1);
    check(matchEn, 1'b1, "R5", "127 pulses stay pending");
    step(1'b1, 1'b0, 1'b0);
    pulses(127, 1'b0);
    check(matchEn, 1'b1, "R5", "count cleared by bus fall");

    phase = "R4";
    step(1'b0, 1'b1, 1'b0);
    check(streamEn, 1'b1, "R4", "fallback on 128th pulse");
    check(streamRestart, 1'b1, "R4", "restart pulse");
    step(1'b0, 1'b0, 1'b0);
    check(streamRestart, 1'b0, "R4", "restart lasts one cycle");

    phase = "R8";
    step(1'b1, 1'b0, 1'b0);
    pulses(127, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check(matchEn, 1'b1, "R8", "bus fall beats stream pulse");
    pulses(127, 1'b1);
    check(matchEn, 1'b1, "R8", "colliding pulse not counted");
    step(1'b0, 1'b1, 1'b1);
    check(slaveEn, 1'b1, "R8", "match beats 128th pulse");
    check(streamRestart, 1'b0, "R8", "no restart on match");

    phase = "R7";
    step(1'b1, 1'b1, 1'b0);
    pulses(300, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    check(slaveEn, 1'b1, "R7", "bus mode latched");
    check(streamEn, 1'b0, "R7", "no return to streaming");

    phase = "R6";
    doReset();
    check(streamEn, 1'b1, "R1", "reset leaves bus mode");
    step(1'b1, 1'b0, 1'b0);
    pulses(50, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    check(slaveEn, 1'b1, "R6", "match commits to bus mode");
    check(matchEn, 1'b0, "R6", "pending left");

    repeat (3) @(negedge clk);
    summary();
  end

endmodule